// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative store of recent page-to-frame translations. Each cycle it can take one lookup: a virtual page number, the current address-space identifier and an access type. It checks that key against every entry at once, and one cycle later it reports a hit with the frame number and permission bits, or a miss. A hit whose permission does not cover the access type is reported as a protection fault.

On a miss, logic outside the block fetches the translation and writes it back through the fill port. The block picks the slot itself. It reuses a slot that already holds the same translation, then takes a free slot, and otherwise evicts the least recently used entry that is not wired. Each entry carries an address-space tag, so translations from several processes can sit side by side without a flush. Entries marked global match any address space. Entries marked wired are never replaced and survive every flush. Two flush commands are provided: one clears the whole buffer and one clears a single address space.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses.
- R2: A lookup presented with `lk_valid` is answered in the next cycle. `rsp_valid` is high and exactly one of `rsp_hit` and `rsp_miss` is high. On a hit, `rsp_pfn` and `rsp_perm` carry the stored frame and permissions. On a miss both are zero.
- R3: An entry hits only when its page number matches and either its stored address-space tag equals `lk_asid` or the entry is global.
- R4: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. `lk_acc` encodes 0 as read, 1 as write, 2 as execute and 3 as reserved. A hit whose access type is not allowed, or whose type is reserved, sets `rsp_fault`, and `rsp_hit` stays high.
- R5: A fill whose page number matches a valid entry with an equal tag (either one global) overwrites that entry. Otherwise the fill goes to the lowest-numbered invalid entry.
- R6: When no entry is invalid, a fill replaces the non-wired entry that was least recently used. A lookup hit and an accepted fill each make their entry the most recent. When both happen in the same cycle, only the fill counts.
- R7: A wired entry is never chosen for replacement.
- R8: When every entry is valid and wired and no entry matches, a fill is refused. The table is left unchanged and `fill_overflow` pulses in the next cycle.
- R9: `flush_all` invalidates every non-wired entry and keeps the wired ones.
- R10: `flush_asid_en` invalidates the non-wired, non-global entries whose tag equals `flush_asid`.
- R11: A lookup sees the table as it stood before any fill or flush in the same cycle. A fill given in the same cycle as a flush is dropped, and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_asid | input | ASID_W | Address-space tag of the fill |
| fill_pfn | input | PFN_W | Frame number of the fill |
| fill_perm | input | 3 | Permissions {X,W,R} of the fill |
| fill_global | input | 1 | Fill matches every address space |
| fill_wired | input | 1 | Fill is protected from replacement and flush |
| flush_all | input | 1 | Invalidate every non-wired entry |
| flush_asid_en | input | 1 | Invalidate the non-wired, non-global entries of one address space |
| flush_asid | input | ASID_W | Address space to flush |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation not found |
| rsp_fault | output | 1 | Hit, but the access type is not permitted |
| rsp_pfn | output | PFN_W | Frame number on a hit, otherwise zero |
| rsp_perm | output | 3 | Permissions on a hit, otherwise zero |
| fill_overflow | output | 1 | The previous cycle's fill was refused |

## Verification
A corrupted recency ordering does not show at once. It appears only at the next eviction, when a different page disappears: a later lookup of the page that should have survived misses, or a lookup of the page that should have been evicted still hits. Wrong tags, global bits or wired bits show in the very next lookup or flush that involves that entry, as a hit that should have been a miss or the reverse. For that reason the random stimulus keeps the page and address-space ranges narrow, so that evictions and refills happen often and any divergence is exposed within a few dozen cycles.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_acc,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [2:0]        fill_perm,
  input  logic              fill_global,
  input  logic              fill_wired,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [2:0]        rsp_perm,
  output logic              fill_overflow
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] v_q, w_q, g_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [2:0]         perm_q [ENTRIES];
  logic [IDX_W-1:0]   age_q  [ENTRIES];

  logic [ENTRIES-1:0] lk_match, fl_match;
  logic               lk_hit, fm_hit, free_ok, vic_ok;
  logic [IDX_W-1:0]   lk_idx, fm_idx, free_idx, vic_idx, vic_age, tgt_idx, touch_idx;
  logic               flush_any, tgt_ok, fill_go, touch_en, acc_ok;

  assign flush_any = flush_all | flush_asid_en;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      lk_match[i] = v_q[i] && vpn_q[i] == lk_vpn && (g_q[i] || asid_q[i] == lk_asid);
      fl_match[i] = v_q[i] && vpn_q[i] == fill_vpn &&
                    (g_q[i] || fill_global || asid_q[i] == fill_asid);
    end
  end

  always_comb begin
    lk_hit = 1'b0; lk_idx = '0;
    fm_hit = 1'b0; fm_idx = '0;
    free_ok = 1'b0; free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) begin lk_hit = 1'b1; lk_idx = IDX_W'(i); end
      if (fl_match[i]) begin fm_hit = 1'b1; fm_idx = IDX_W'(i); end
      if (!v_q[i])     begin free_ok = 1'b1; free_idx = IDX_W'(i); end
    end
  end

  always_comb begin
    vic_ok = 1'b0; vic_idx = '0; vic_age = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!w_q[i] && (!vic_ok || age_q[i] > vic_age)) begin
        vic_ok = 1'b1; vic_idx = IDX_W'(i); vic_age = age_q[i];
      end
    end
  end

  always_comb begin
    tgt_ok  = 1'b1;
    tgt_idx = vic_idx;
    if (fm_hit)       tgt_idx = fm_idx;
    else if (free_ok) tgt_idx = free_idx;
    else if (!vic_ok) tgt_ok  = 1'b0;
  end

  assign fill_go   = fill_valid && !flush_any && tgt_ok;
  assign touch_en  = fill_go || (lk_valid && lk_hit);
  assign touch_idx = fill_go ? tgt_idx : lk_idx;

  always_comb begin
    case (lk_acc)
      2'd0:    acc_ok = perm_q[lk_idx][0];
      2'd1:    acc_ok = perm_q[lk_idx][1];
      2'd2:    acc_ok = perm_q[lk_idx][2];
      default: acc_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0; w_q <= '0; g_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        asid_q[i] <= '0;
        pfn_q[i]  <= '0;
        perm_q[i] <= '0;
        age_q[i]  <= IDX_W'(i);
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!w_q[i] && (flush_all ||
            (flush_asid_en && !g_q[i] && asid_q[i] == flush_asid)))
          v_q[i] <= 1'b0;
        if (touch_en) begin
          if (touch_idx == IDX_W'(i))        age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
      if (fill_go) begin
        v_q[tgt_idx]    <= 1'b1;
        w_q[tgt_idx]    <= fill_wired;
        g_q[tgt_idx]    <= fill_global;
        vpn_q[tgt_idx]  <= fill_vpn;
        asid_q[tgt_idx] <= fill_asid;
        pfn_q[tgt_idx]  <= fill_pfn;
        perm_q[tgt_idx] <= fill_perm;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_miss <= 1'b0; rsp_fault <= 1'b0;
      rsp_pfn <= '0; rsp_perm <= '0; fill_overflow <= 1'b0;
    end else begin
      rsp_valid     <= lk_valid;
      rsp_hit       <= lk_valid && lk_hit;
      rsp_miss      <= lk_valid && !lk_hit;
      rsp_fault     <= lk_valid && lk_hit && !acc_ok;
      rsp_pfn       <= (lk_valid && lk_hit) ? pfn_q[lk_idx] : '0;
      rsp_perm      <= (lk_valid && lk_hit) ? perm_q[lk_idx] : '0;
      fill_overflow <= fill_valid && !flush_any && !tgt_ok;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss}) == 1); // R2
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pfn == '0 && rsp_perm == '0 && !rsp_fault)); // R2
  AST_FAULT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_overflow |-> $past(&(w_q & v_q))); // R8

  for (genvar k = 0; k < ENTRIES; k++) begin : g_wired_chk
    AST_WIRED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q[k] && w_q[k]) |=> v_q[k]); // R7
  end
endmodule

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
  localparam int N = 16, VW = 20, PW = 16, AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid, fill_valid, fill_global, fill_wired, flush_all, flush_asid_en;
  logic [VW-1:0] lk_vpn, fill_vpn;
  logic [AW-1:0] lk_asid, fill_asid, flush_asid;
  logic [1:0] lk_acc;
  logic [PW-1:0] fill_pfn;
  logic [2:0] fill_perm;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, fill_overflow;
  logic [PW-1:0] rsp_pfn;
  logic [2:0] rsp_perm;

  always #10 clk = ~clk;

  asid_tlb #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) i_asid_tlb (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_acc(lk_acc), .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_global(fill_global),
    .fill_wired(fill_wired), .flush_all(flush_all), .flush_asid_en(flush_asid_en),
    .flush_asid(flush_asid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm),
    .fill_overflow(fill_overflow));

  bit m_v[N], m_w[N], m_g[N];
  logic [VW-1:0] m_vpn[N];
  logic [AW-1:0] m_asid[N];
  logic [PW-1:0] m_pfn[N];
  logic [2:0] m_perm[N];
  int m_age[N];
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  function automatic int find_lookup(logic [VW-1:0] vpn, logic [AW-1:0] asid);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asid[i] == asid)) return i;
    return -1;
  endfunction

  function automatic int find_target();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == fill_vpn && (m_g[i] || fill_global || m_asid[i] == fill_asid))
        return i;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 0; i < N; i++)
      if (!m_w[i] && (best < 0 || m_age[i] > m_age[best])) best = i;
    return best;
  endfunction

  function automatic void touch(int t);
    int a = m_age[t];
    for (int i = 0; i < N; i++) if (m_age[i] < a) m_age[i]++;
    m_age[t] = 0;
  endfunction

  function automatic bit acc_allowed(logic [2:0] p, logic [1:0] a);
    return (a == 2'd3) ? 1'b0 : p[a];
  endfunction

  task automatic idle();
    lk_valid = 0; lk_vpn = '0; lk_asid = '0; lk_acc = '0;
    fill_valid = 0; fill_vpn = '0; fill_asid = '0; fill_pfn = '0; fill_perm = '0;
    fill_global = 0; fill_wired = 0; flush_all = 0; flush_asid_en = 0; flush_asid = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_w[i] = 0; m_g[i] = 0; m_age[i] = i; end
    rst_n = 1;
  endtask

  task automatic tick(string tag);
    int h, t;
    logic [PW+6:0] exp_v, got_v;
    bit ovf = 0;
    h = lk_valid ? find_lookup(lk_vpn, lk_asid) : -1;
    exp_v = {lk_valid, h >= 0, lk_valid && h < 0,
             h >= 0 && !acc_allowed(m_perm[h], lk_acc),
             (h >= 0) ? m_pfn[h] : {PW{1'b0}}, (h >= 0) ? m_perm[h] : 3'b0, 1'b0};
    if (flush_all || flush_asid_en) begin
      for (int i = 0; i < N; i++)
        if (!m_w[i] && (flush_all || (!m_g[i] && m_asid[i] == flush_asid))) m_v[i] = 0;
      if (h >= 0) touch(h);
    end else if (fill_valid) begin
      t = find_target();
      if (t < 0) begin
        ovf = 1;
        if (h >= 0) touch(h);
      end else begin
        m_v[t] = 1; m_w[t] = fill_wired; m_g[t] = fill_global; m_vpn[t] = fill_vpn;
        m_asid[t] = fill_asid; m_pfn[t] = fill_pfn; m_perm[t] = fill_perm;
        touch(t);
      end
    end else if (h >= 0) touch(h);
    exp_v[0] = ovf;
    @(posedge clk);
    @(negedge clk);
    got_v = {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_pfn, rsp_perm, fill_overflow};
    checks++;
    if (got_v !== exp_v) begin
      fails++;
      $display("FAIL %s: {valid,hit,miss,fault,pfn,perm,ovf} got %h expected %h", tag, got_v, exp_v);
    end
    idle();
  endtask

  task automatic look(logic [VW-1:0] v, logic [AW-1:0] a, logic [1:0] acc, string tag);
    lk_valid = 1; lk_vpn = v; lk_asid = a; lk_acc = acc;
    tick(tag);
  endtask

  task automatic fill(logic [VW-1:0] v, logic [AW-1:0] a, logic [PW-1:0] p, logic [2:0] pm,
                      bit g, bit w, string tag);
    fill_valid = 1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_perm = pm;
    fill_global = g; fill_wired = w;
    tick(tag);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    look(20'd5, 8'd0, 2'd0, "R1");
    look(20'd0, 8'd0, 2'd0, "R1");
    fill(20'd1, 8'd1, 16'hA001, 3'b111, 0, 0, "R5");
    look(20'd1, 8'd1, 2'd1, "R2");
    fill(20'd1, 8'd1, 16'hB001, 3'b011, 0, 0, "R5");
    look(20'd1, 8'd1, 2'd0, "R5");
    look(20'd1, 8'd2, 2'd0, "R3");
    fill(20'd2, 8'd7, 16'h0C02, 3'b101, 1, 0, "R3");
    look(20'd2, 8'd3, 2'd2, "R3");
    fill(20'd3, 8'd1, 16'h0D03, 3'b001, 0, 0, "R4");
    look(20'd3, 8'd1, 2'd1, "R4");
    look(20'd3, 8'd1, 2'd2, "R4");
    look(20'd3, 8'd1, 2'd3, "R4");
    look(20'd3, 8'd1, 2'd0, "R4");

    do_reset();
    for (int i = 0; i < N; i++) fill(VW'(i), 8'd1, PW'(16'h100 + i), 3'b111, 0, i == 0, "R6");
    look(20'd1, 8'd1, 2'd0, "R6");
    fill(20'd40, 8'd1, 16'h0040, 3'b111, 0, 0, "R6");
    look(20'd2, 8'd1, 2'd0, "R6");
    look(20'd0, 8'd1, 2'd0, "R7");
    look(20'd1, 8'd1, 2'd0, "R6");
    lk_valid = 1; lk_vpn = 20'd3; lk_asid = 8'd1;
    fill_valid = 1; fill_vpn = 20'd41; fill_asid = 8'd1; fill_pfn = 16'h41; fill_perm = 3'b001;
    tick("R6");
    look(20'd4, 8'd1, 2'd0, "R6");
    look(20'd3, 8'd1, 2'd0, "R6");
    lk_valid = 1; lk_vpn = 20'd42; lk_asid = 8'd1;
    fill_valid = 1; fill_vpn = 20'd42; fill_asid = 8'd1; fill_pfn = 16'h42; fill_perm = 3'b001;
    tick("R11");
    look(20'd42, 8'd1, 2'd0, "R11");
    fill_valid = 1; fill_vpn = 20'd43; fill_asid = 8'd1; fill_pfn = 16'h43; fill_perm = 3'b001;
    flush_asid_en = 1; flush_asid = 8'd9;
    tick("R11");
    look(20'd43, 8'd1, 2'd0, "R11");
    flush_all = 1; tick("R9");
    look(20'd0, 8'd1, 2'd0, "R9");
    look(20'd42, 8'd1, 2'd0, "R9");

    do_reset();
    fill(20'd10, 8'd1, 16'h0110, 3'b111, 0, 0, "R10");
    fill(20'd11, 8'd2, 16'h0211, 3'b111, 0, 0, "R10");
    fill(20'd12, 8'd1, 16'h0312, 3'b111, 1, 0, "R10");
    fill(20'd13, 8'd1, 16'h0413, 3'b111, 0, 1, "R10");
    flush_asid_en = 1; flush_asid = 8'd1; tick("R10");
    look(20'd10, 8'd1, 2'd0, "R10");
    look(20'd11, 8'd2, 2'd0, "R10");
    look(20'd12, 8'd1, 2'd0, "R10");
    look(20'd13, 8'd1, 2'd0, "R10");

    do_reset();
    for (int i = 0; i < N; i++) fill(VW'(i + 50), 8'd3, PW'(i), 3'b001, 0, 1, "R8");
    fill(20'd99, 8'd3, 16'h0099, 3'b001, 0, 0, "R8");
    look(20'd99, 8'd3, 2'd0, "R8");
    for (int i = 0; i < N; i++) look(VW'(i + 50), 8'd3, 2'd0, "R8");
    flush_all = 1; tick("R9");
    look(20'd57, 8'd3, 2'd0, "R9");

    for (int blk = 0; blk < 4; blk++) begin
      do_reset();
      for (int k = 0; k < 800; k++) begin
        int r = $urandom_range(0, 199);
        lk_valid = ($urandom_range(0, 9) < 7);
        lk_vpn = VW'($urandom_range(0, 23));
        lk_asid = AW'($urandom_range(0, 3));
        lk_acc = 2'($urandom_range(0, 3));
        if (r == 0) flush_all = 1;
        else if (r < 4) begin flush_asid_en = 1; flush_asid = AW'($urandom_range(0, 3)); end
        if ($urandom_range(0, 9) < 3) begin
          fill_valid = 1;
          fill_vpn = VW'($urandom_range(0, 23));
          fill_asid = AW'($urandom_range(0, 3));
          fill_pfn = PW'($urandom);
          fill_perm = 3'($urandom_range(0, 7));
          fill_global = ($urandom_range(0, 7) == 0);
          fill_wired = ($urandom_range(0, 39) == 0);
        end
        tick("R6");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule